// File: doc/BRIEF.md
# Dual-Phase I2C SCL Clock Generator

This block produces the master-side SCL waveform for an I2C controller. It supports standard and fast speeds and a two-phase high-speed transfer. A functional clock drives everything. An 8-bit prescale value divides that clock into an internal sampling tick. The low and high halves of each SCL period are then counted in ticks. Each half has a fixed extra count added: +7 on the low half, +5 on the high half.

A phase-select input moves the generator to the fast second phase of a high-speed transfer. In that phase the prescaler is bypassed, and the low and high halves are counted in raw functional-clock cycles using a separate pair of fields. Each period starts with its low half. The generator drives SCL only while it is enabled and configured as bus master; otherwise the line is released.

A one-cycle pulse marks each falling edge and each rising edge that the generator produces. A data-shifting block can use these pulses as its timing. All timing fields are captured while the block is disabled and stay frozen while it runs.

Top module: `dual_phase_scl_gen`

## Requirements
- R1: The timing fields are sampled at every clock edge while `en` is low, so the values present in the last cycle before `en` rises are the ones used. The low-count input carries the standard/fast value in bits [7:0] and the second-phase value in bits [15:8]. The high-count input uses the same layout.
- R2: With phase two not selected, P = `prescale`, and L = bits [7:0] of the low-count input, each low half lasts (L+7)·(P+1) clock cycles and contains exactly L+7 `sample_tick` cycles.
- R3: With phase two not selected and H = bits [7:0] of the high-count input, each high half lasts (H+5)·(P+1) clock cycles.
- R4: In phase two, with HL = bits [15:8] of the low-count input and HH = bits [15:8] of the high-count input, the low half lasts HL+7 cycles and the high half HH+5 cycles. `sample_tick` is high on every cycle in this phase.
- R5: While `en` stays high, changes on `prescale`, `low_count_cfg` and `high_count_cfg` have no effect on the waveform.
- R6: While `en` or `master_mode` is low, `scl_pull_low`, `sample_tick`, `scl_fall_pulse` and `scl_rise_pulse` are 0. Dropping either input releases SCL on the next clock edge, and no rise pulse is produced for this release.
- R7: The first clock edge that sees `en` and `master_mode` both high starts a low half: `scl_pull_low` is 1 from that edge. Every restart of the generator begins again from a full low half.
- R8: `hs_phase_sel` is sampled only at the edge that starts a low half. A change made at any other time first affects the next low half, even if it arrives in the last cycle of a high half.
- R9: `scl_fall_pulse` is high for exactly the first cycle of each low half. `scl_rise_pulse` is high for exactly the first cycle of each high half.
- R10: With a 96 MHz clock, the following settings give these periods. P=23, L=13, H=15 gives a 960-cycle period (100 kHz) with a tick every 24 cycles. P=9, L=5, H=7 gives a 240-cycle period (400 kHz). HL=12, HH=5 in phase two gives a 29-cycle period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Controller enable; freezes timing fields while high |
| master_mode | input | 1 | High when this controller is bus master |
| hs_phase_sel | input | 1 | Selects high-speed phase two timing (prescaler bypass) |
| prescale | input | 8 | Prescale value P; tick = clk / (P+1) |
| low_count_cfg | input | 16 | [7:0] standard/fast low count, [15:8] phase-two low count |
| high_count_cfg | input | 16 | [7:0] standard/fast high count, [15:8] phase-two high count |
| sample_tick | output | 1 | Internal sampling tick |
| scl_pull_low | output | 1 | 1 = drive SCL low, 0 = release |
| scl_fall_pulse | output | 1 | One-cycle mark of a generated falling edge |
| scl_rise_pulse | output | 1 | One-cycle mark of a generated rising edge |

## Verification
Two events can fall on the same clock edge: the end of a high half, which restarts the prescaler and samples the phase select, and a change of the phase select. The bench provokes this by flipping `hs_phase_sel` in the very last high cycle. A flip is also made in the middle of a half. The bench then measures the following low and high halves. Each measured length must match the newly selected mode exactly, with no truncated half and no leftover prescaler offset. The earlier half must keep the old timing.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;
  typedef enum logic {SEG_LOW = 1'b0, SEG_HIGH = 1'b1} seg_t;
  localparam int LOW_EXTRA  = 7;
  localparam int HIGH_EXTRA = 5;
endpackage

// File: rtl/sclgen_cfg_hold.sv
module sclgen_cfg_hold #(
  parameter int PSC_W   = 8,
  parameter int FIELD_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en_i,
  input  logic [PSC_W-1:0]     psc_i,
  input  logic [2*FIELD_W-1:0] low_i,
  input  logic [2*FIELD_W-1:0] high_i,
  output logic [PSC_W-1:0]     psc_o,
  output logic [2*FIELD_W-1:0] low_o,
  output logic [2*FIELD_W-1:0] high_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      psc_o  <= '0;
      low_o  <= '0;
      high_o <= '0;
    end else if (!en_i) begin
      psc_o  <= psc_i;
      low_o  <= low_i;
      high_o <= high_i;
    end
  end

  assert_cfg_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    (en_i && $past(en_i)) |-> ($stable(psc_o) && $stable(low_o) && $stable(high_o)));
endmodule

// File: rtl/sclgen_prescaler.sv
module sclgen_prescaler #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] cnt_q;
  logic [PSC_W-1:0] base;

  assign base = restart_i ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (base == psc_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= base + PSC_W'(1);
      tick_o <= 1'b0;
    end
  end

  assert_div_range_R2: assert property (@(posedge clk) disable iff (rst)
    run_i |-> (cnt_q <= psc_i));
  assert_tick_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> !tick_o);
endmodule

// File: rtl/sclgen_phase_timer.sv
module sclgen_phase_timer
  import sclgen_pkg::*;
#(
  parameter int FIELD_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run_i,
  input  logic               tick_i,
  input  logic               hs_sel_i,
  input  logic [FIELD_W-1:0] fs_low_i,
  input  logic [FIELD_W-1:0] fs_high_i,
  input  logic [FIELD_W-1:0] hs_low_i,
  input  logic [FIELD_W-1:0] hs_high_i,
  output logic               low_start_o,
  output logic               active_o,
  output logic               bypass_o,
  output logic               pull_low_o,
  output logic               fall_o,
  output logic               rise_o
);
  localparam int CNT_W = FIELD_W + 1;

  seg_t             seg_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_now;
  logic             active_q, bypass_q;
  logic             step, last;

  always_comb begin
    if (seg_q == SEG_LOW)
      len_now = CNT_W'(bypass_q ? hs_low_i : fs_low_i) + CNT_W'(LOW_EXTRA);
    else
      len_now = CNT_W'(bypass_q ? hs_high_i : fs_high_i) + CNT_W'(HIGH_EXTRA);
  end

  assign step        = bypass_q | tick_i;
  assign last        = active_q & step & (cnt_q == len_now - CNT_W'(1));
  assign low_start_o = last & (seg_q == SEG_HIGH);
  assign active_o    = active_q;
  assign bypass_o    = bypass_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      active_q   <= 1'b0;
      seg_q      <= SEG_LOW;
      cnt_q      <= '0;
      bypass_q   <= 1'b0;
      pull_low_o <= 1'b0;
      fall_o     <= 1'b0;
      rise_o     <= 1'b0;
    end else if (!active_q) begin
      active_q   <= 1'b1;
      seg_q      <= SEG_LOW;
      cnt_q      <= '0;
      bypass_q   <= hs_sel_i;
      pull_low_o <= 1'b1;
      fall_o     <= 1'b1;
      rise_o     <= 1'b0;
    end else begin
      fall_o <= 1'b0;
      rise_o <= 1'b0;
      if (last) begin
        cnt_q <= '0;
        if (seg_q == SEG_LOW) begin
          seg_q      <= SEG_HIGH;
          pull_low_o <= 1'b0;
          rise_o     <= 1'b1;
        end else begin
          seg_q      <= SEG_LOW;
          pull_low_o <= 1'b1;
          fall_o     <= 1'b1;
          bypass_q   <= hs_sel_i;
        end
      end else if (step) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    active_q |-> (cnt_q < len_now));
  assert_release_R6: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (!pull_low_o && !fall_o && !rise_o));
  assert_fall_mark_R9: assert property (@(posedge clk) disable iff (rst)
    fall_o == $rose(pull_low_o));
  assert_rise_mark_R9: assert property (@(posedge clk) disable iff (rst)
    rise_o |-> $fell(pull_low_o));
  assert_phase_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (active_q && $past(active_q) && (bypass_q != $past(bypass_q))) |-> fall_o);
endmodule

// File: rtl/dual_phase_scl_gen.sv
module dual_phase_scl_gen #(
  parameter int PSC_W   = 8,
  parameter int FIELD_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 master_mode,
  input  logic                 hs_phase_sel,
  input  logic [PSC_W-1:0]     prescale,
  input  logic [2*FIELD_W-1:0] low_count_cfg,
  input  logic [2*FIELD_W-1:0] high_count_cfg,
  output logic                 sample_tick,
  output logic                 scl_pull_low,
  output logic                 scl_fall_pulse,
  output logic                 scl_rise_pulse
);
  logic [PSC_W-1:0]     psc_h;
  logic [2*FIELD_W-1:0] low_h, high_h;
  logic                 run, ptick, low_start, active, bypass;

  assign run = en & master_mode;

  sclgen_cfg_hold #(.PSC_W(PSC_W), .FIELD_W(FIELD_W)) u_cfg (
    .clk(clk), .rst(rst), .en_i(en),
    .psc_i(prescale), .low_i(low_count_cfg), .high_i(high_count_cfg),
    .psc_o(psc_h), .low_o(low_h), .high_o(high_h)
  );

  sclgen_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst(rst), .run_i(run), .restart_i(low_start),
    .psc_i(psc_h), .tick_o(ptick)
  );

  sclgen_phase_timer #(.FIELD_W(FIELD_W)) u_timer (
    .clk(clk), .rst(rst), .run_i(run), .tick_i(ptick), .hs_sel_i(hs_phase_sel),
    .fs_low_i(low_h[FIELD_W-1:0]), .fs_high_i(high_h[FIELD_W-1:0]),
    .hs_low_i(low_h[2*FIELD_W-1:FIELD_W]), .hs_high_i(high_h[2*FIELD_W-1:FIELD_W]),
    .low_start_o(low_start), .active_o(active), .bypass_o(bypass),
    .pull_low_o(scl_pull_low), .fall_o(scl_fall_pulse), .rise_o(scl_rise_pulse)
  );

  assign sample_tick = active & (bypass | ptick);

  assert_tick_needs_run_R6: assert property (@(posedge clk) disable iff (rst)
    !run |=> !sample_tick);
endmodule

// File: tb/dual_phase_scl_gen_bench.sv
module dual_phase_scl_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0, master_mode = 1'b1, hs_phase_sel = 1'b0;
  logic [7:0]  prescale = '0;
  logic [15:0] low_count_cfg = '0, high_count_cfg = '0;
  logic        sample_tick, scl_pull_low, scl_fall_pulse, scl_rise_pulse;

  int tests = 0, fails = 0, cycles = 0;

  dual_phase_scl_gen u_dual_phase_scl_gen (
    .clk(clk), .rst(rst), .en(en), .master_mode(master_mode),
    .hs_phase_sel(hs_phase_sel), .prescale(prescale),
    .low_count_cfg(low_count_cfg), .high_count_cfg(high_count_cfg),
    .sample_tick(sample_tick), .scl_pull_low(scl_pull_low),
    .scl_fall_pulse(scl_fall_pulse), .scl_rise_pulse(scl_rise_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        $display("FAIL watchdog expired: actual %0d cycles, expected < %0d", cycles, WATCHDOG);
        fails++;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setcfg(input int p, input int fl, input int fh, input int hl, input int hh);
    prescale       = 8'(p);
    low_count_cfg  = {8'(hl), 8'(fl)};
    high_count_cfg = {8'(hh), 8'(fh)};
  endtask

  // Called at a negedge; returns at the negedge of the first low cycle.
  task automatic start_run(input string req);
    en = 1'b1;
    @(negedge clk);
    chk(scl_pull_low == 1'b1, {req, " start low"}, int'(scl_pull_low), 1);
    chk(scl_fall_pulse == 1'b1, {req, " R9 first fall pulse"}, int'(scl_fall_pulse), 1);
  endtask

  task automatic stop_run(input string req);
    en = 1'b0;
    @(negedge clk);
    chk({scl_pull_low, sample_tick, scl_fall_pulse, scl_rise_pulse} == 4'b0,
        {req, " R6 released after disable"},
        int'({scl_pull_low, sample_tick, scl_fall_pulse, scl_rise_pulse}), 0);
    @(negedge clk);
  endtask

  // Entered at the first low-cycle negedge; leaves at the next period's first low cycle.
  task automatic measure(output int lo, output int hi, output int ticks, output int bad,
                         input int flip_at, input logic flip_val);
    lo = 0; hi = 0; ticks = 0; bad = 0;
    while (scl_pull_low === 1'b1 && lo < 4000) begin
      lo++;
      if (sample_tick) ticks++;
      if (lo > 1 && scl_fall_pulse) bad++;
      if (scl_rise_pulse) bad++;
      @(negedge clk);
    end
    if (!scl_rise_pulse) bad++;
    while (scl_pull_low === 1'b0 && hi < 4000) begin
      hi++;
      if (hi > 1 && scl_rise_pulse) bad++;
      if (scl_fall_pulse) bad++;
      if (hi == flip_at) hs_phase_sel = flip_val;
      @(negedge clk);
    end
    if (!scl_fall_pulse) bad++;
  endtask

  task automatic period_chk(input string req, input int elo, input int ehi, input int etk,
                            input int flip_at, input logic flip_val);
    int lo, hi, tk, bad;
    measure(lo, hi, tk, bad, flip_at, flip_val);
    chk(lo == elo, {req, " low length"}, lo, elo);
    chk(hi == ehi, {req, " high length"}, hi, ehi);
    chk(tk == etk, {req, " ticks in low"}, tk, etk);
    chk(bad == 0, {req, " R9 edge pulses"}, bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({scl_pull_low, sample_tick, scl_fall_pulse, scl_rise_pulse} == 4'b0,
        "R6 reset state", int'({scl_pull_low, sample_tick, scl_fall_pulse, scl_rise_pulse}), 0);

    // Sweep: R2 R3 (phase one) and R4 (phase two), fields in R1 layout
    for (int ph = 0; ph < 2; ph++) begin
      for (int p = 0; p < 4; p++) begin
        for (int l = 0; l < 3; l++) begin
          for (int h = 0; h < 3; h++) begin
            hs_phase_sel = ph[0];
            if (ph == 0) setcfg(p, l, h, l + 4, h + 4);
            else         setcfg(p, l + 3, h + 3, l, h);
            @(negedge clk);
            start_run("R7");
            for (int k = 0; k < 2; k++) begin
              if (ph == 0) period_chk("R2 R3 sweep", (l+7)*(p+1), (h+5)*(p+1), l+7, 0, 1'b0);
              else         period_chk("R4 sweep", l+7, h+5, l+7, 0, 1'b1);
            end
            stop_run("R6");
          end
        end
      end
    end

    // R10 reference settings
    hs_phase_sel = 1'b0;
    setcfg(23, 13, 15, 0, 0); @(negedge clk); start_run("R10");
    period_chk("R10 100k", 480, 480, 20, 0, 1'b0);
    stop_run("R10");
    setcfg(9, 5, 7, 0, 0); @(negedge clk); start_run("R10");
    period_chk("R10 400k", 120, 120, 12, 0, 1'b0);
    stop_run("R10");
    hs_phase_sel = 1'b1;
    setcfg(1, 115, 113, 12, 5); @(negedge clk); start_run("R10");
    period_chk("R10 hs 29-cycle", 19, 10, 19, 0, 1'b1);
    stop_run("R10");

    // R5: changes while enabled ignored; R1: new values taken after re-enable
    hs_phase_sel = 1'b0;
    setcfg(1, 2, 1, 0, 0); @(negedge clk); start_run("R5");
    setcfg(5, 9, 9, 9, 9);
    period_chk("R5 frozen", 18, 12, 9, 0, 1'b0);
    period_chk("R5 frozen", 18, 12, 9, 0, 1'b0);
    stop_run("R5");
    start_run("R1");
    period_chk("R1 recaptured", 96, 84, 16, 0, 1'b0);
    stop_run("R1");

    // R8: phase switching, including a flip in the last high cycle
    setcfg(2, 1, 0, 3, 2); @(negedge clk); start_run("R8");
    hs_phase_sel = 1'b1;                              // mid-low flip
    period_chk("R8 old phase kept", 24, 15, 8, 0, 1'b0);
    period_chk("R8 new phase", 10, 7, 10, 7, 1'b0); // flip in last high cycle
    period_chk("R8 last-cycle flip", 24, 15, 8, 1, 1'b1);
    period_chk("R8 back to phase two", 10, 7, 10, 0, 1'b1);
    stop_run("R8");

    // R6 master_mode low: no clock; R7 restart on master
    hs_phase_sel = 1'b0;
    setcfg(0, 0, 0, 0, 0); @(negedge clk);
    master_mode = 1'b0;
    en = 1'b1;
    begin
      int seen = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (scl_pull_low || sample_tick || scl_fall_pulse || scl_rise_pulse) seen++;
      end
      chk(seen == 0, "R6 slave no clock", seen, 0);
    end
    master_mode = 1'b1;
    @(negedge clk);
    chk(scl_pull_low == 1'b1, "R7 start on master", int'(scl_pull_low), 1);
    period_chk("R7 full first low", 7, 5, 7, 0, 1'b0);
    // R6 abort in mid low, no rise pulse
    @(negedge clk); @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(scl_pull_low == 1'b0 && scl_rise_pulse == 1'b0, "R6 abort release",
        int'({scl_pull_low, scl_rise_pulse}), 0);
    @(negedge clk);
    start_run("R7 restart");
    period_chk("R7 restart full low", 7, 5, 7, 0, 1'b0);
    stop_run("R6");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule